// File: doc/BRIEF.md
# LDPC Check Node Unit

This block performs the check-side update of a log-domain belief-propagation decoder for a code whose check nodes each have six edges. On every valid cycle it accepts six 6-bit words from the variable side. Each word carries the variable node's current hard decision and its variable-to-check message in sign-magnitude form. From these it returns six sign-magnitude check-to-variable messages and one bit that reports whether this parity check is violated.

For each edge, the returned message leaves that edge's own input out of the computation. Its sign is the parity of the other five sign bits. Its magnitude is the quantized log-tanh transfer function ln((1+e^-x)/(1-e^-x)) applied to the sum of the other five magnitudes. One register splits the unit into two halves. The first half holds the exclusion sums, the sign logic and the hard-decision parity. The second half is a small combinational table for the transfer function.

The stop logic of a decoder collects the parity bits from many such units. The message memories feed the units through routing networks that sit outside this block.

Top module: `ldpc_cnu`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, `out_valid` is low after that edge.
- R2: `out_valid` at the end of a cycle equals `in_valid` sampled at that cycle's rising edge. The latency is exactly one clock.
- R3: Edge j occupies bits [6j+5:6j] of `in_words`, with the hard decision at bit 6j+5. For each accepted word set, `out_parity` equals the XOR of the six hard-decision bits.
- R4: Within edge j's input field, bit 6j+4 is the sign, with 1 meaning negative. Message j occupies bits [5j+4:5j] of `out_msgs`, and its sign bit 5j+4 equals the XOR of the sign bits of the five other edges.
- R5: Input magnitudes sit at bits [6j+3:6j] and output magnitudes at bits [5j+3:5j], with one LSB worth 0.25. Output magnitude j is f(s/4)·4 rounded to the nearest integer and capped at 15, where s is the sum of the other five input magnitudes and f(x)=ln((1+e^-x)/(1-e^-x)). When s is 0 the output magnitude is 15.
- R6: When the sum of the other five magnitudes is 15 or more, up to the maximum of 75, the output magnitude is 0. The sum never wraps into a small value.
- R7: The hard-decision bits have no effect on `out_msgs`, and the input signs have no effect on any output magnitude.
- R8: Changing edge j's own input magnitude leaves output magnitude j unchanged.
- R9: A cycle with `in_valid` low leaves `out_msgs` and `out_parity` at their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid stage |
| in_valid | input | 1 | The six input words are valid this cycle |
| in_words | input | 36 | Six hybrid words {hard, sign, magnitude[3:0]}, edge j at [6j+5:6j] |
| out_valid | output | 1 | Outputs hold a fresh result |
| out_msgs | output | 30 | Six check-to-variable messages {sign, magnitude[3:0]}, edge j at [5j+4:5j] |
| out_parity | output | 1 | XOR of the six hard decisions (1 means the check fails) |

## Verification
The register sits between the exclusion logic and the table, so a wrong stored sum or sign shows up on the outputs one clock after the offending input. It appears as a wrong magnitude or sign on exactly the edges whose stored field is damaged. A wrong total-minus-own subtraction shows on every edge that has nonzero neighbours. A missing saturation shows only when some exclusion sum reaches 16 or more, because the wrapped index then points at a nonzero table entry. The directed cases therefore straddle that boundary. A hold fault in the load enable shows one cycle after an idle input, as a changed message on otherwise frozen outputs.

// File: rtl/ldpc_cnu_pkg.sv
package ldpc_cnu_pkg;

    // Structure of one check node and of its quantised messages
    localparam int DEG       = 6;
    localparam int MAG_W     = 4;
    localparam int MSG_W     = MAG_W + 1;
    localparam int WORD_W    = MSG_W + 1;
    localparam int MAG_MAX   = (1 << MAG_W) - 1;
    localparam int SUM_W     = $clog2(DEG * MAG_MAX + 1);
    localparam int LUT_IN_W  = 4;
    localparam int LUT_TOP   = (1 << LUT_IN_W) - 1;
    localparam int RAW_W     = MAG_W + 1;

    // Variable-to-check word as it arrives from the memory side
    typedef struct packed {
        logic             hard;
        logic             sgn;
        logic [MAG_W-1:0] mag;
    } v2c_word_t;

    // Check-to-variable message as it leaves the unit
    typedef struct packed {
        logic             sgn;
        logic [MAG_W-1:0] mag;
    } c2v_msg_t;

    // Contents of the mid-pipeline register
    typedef struct packed {
        logic                               parity;
        logic [DEG-1:0]                     xsgn;
        logic [DEG-1:0][LUT_IN_W-1:0]       xidx;
    } mid_stage_t;

    // Clamp an exclusion sum onto the table's input range
    function automatic logic [LUT_IN_W-1:0] clamp_sum(input logic [SUM_W-1:0] s);
        if (s > SUM_W'(LUT_TOP))
            return LUT_IN_W'(LUT_TOP);
        return s[LUT_IN_W-1:0];
    endfunction

    // Quantised ln((1+e^-x)/(1-e^-x)), input and output LSB = 0.25.
    // Index 0 stands for an unbounded result and is clipped below.
    function automatic logic [MAG_W-1:0] phi_lookup(input logic [LUT_IN_W-1:0] idx);
        logic [RAW_W-1:0] raw;
        case (idx)
            LUT_IN_W'(0):  raw = RAW_W'(31);
            LUT_IN_W'(1):  raw = RAW_W'(8);
            LUT_IN_W'(2):  raw = RAW_W'(6);
            LUT_IN_W'(3):  raw = RAW_W'(4);
            LUT_IN_W'(4):  raw = RAW_W'(3);
            LUT_IN_W'(5):  raw = RAW_W'(2);
            LUT_IN_W'(6):  raw = RAW_W'(2);
            LUT_IN_W'(7):  raw = RAW_W'(1);
            LUT_IN_W'(8):  raw = RAW_W'(1);
            LUT_IN_W'(9):  raw = RAW_W'(1);
            LUT_IN_W'(10): raw = RAW_W'(1);
            LUT_IN_W'(11): raw = RAW_W'(1);
            default:       raw = '0;
        endcase
        if (raw > RAW_W'(MAG_MAX))
            return MAG_W'(MAG_MAX);
        return raw[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/cnu_extrinsic.sv
module cnu_extrinsic
    import ldpc_cnu_pkg::*;
(
    input  v2c_word_t  words [DEG],
    output mid_stage_t mid
);

    logic [SUM_W-1:0] mag_total;
    logic             sgn_total;
    logic             hard_total;

    // Totals over all edges, each edge then removes itself
    always_comb begin
        mag_total  = '0;
        sgn_total  = 1'b0;
        hard_total = 1'b0;
        for (int e = 0; e < DEG; e++) begin
            mag_total  = mag_total + SUM_W'(words[e].mag);
            sgn_total  = sgn_total ^ words[e].sgn;
            hard_total = hard_total ^ words[e].hard;
        end
    end

    assign mid.parity = hard_total;

    for (genvar g = 0; g < DEG; g++) begin : g_edge
        logic [SUM_W-1:0] others;
        assign others        = mag_total - SUM_W'(words[g].mag);
        assign mid.xsgn[g]   = sgn_total ^ words[g].sgn;
        assign mid.xidx[g]   = clamp_sum(others);
    end

endmodule

// File: rtl/cnu_stage.sv
module cnu_stage
    import ldpc_cnu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  mid_stage_t d,
    output logic       q_valid,
    output mid_stage_t q
);

    always_ff @(posedge clk) begin
        if (rst)
            q_valid <= 1'b0;
        else
            q_valid <= in_valid;
    end

    // Payload has no reset: it is qualified by q_valid
    always_ff @(posedge clk) begin
        if (in_valid)
            q <= d;
    end

endmodule

// File: rtl/cnu_lookup.sv
module cnu_lookup
    import ldpc_cnu_pkg::*;
(
    input  mid_stage_t           q,
    output logic [DEG*MSG_W-1:0] msgs
);

    for (genvar g = 0; g < DEG; g++) begin : g_edge
        c2v_msg_t m;
        assign m.sgn = q.xsgn[g];
        assign m.mag = phi_lookup(q.xidx[g]);
        assign msgs[g*MSG_W +: MSG_W] = m;
    end

endmodule

// File: rtl/ldpc_cnu.sv
module ldpc_cnu
    import ldpc_cnu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DEG*WORD_W-1:0] in_words,
    output logic                  out_valid,
    output logic [DEG*MSG_W-1:0]  out_msgs,
    output logic                  out_parity
);

    v2c_word_t  words [DEG];
    mid_stage_t mid_d;
    mid_stage_t mid_q;

    for (genvar g = 0; g < DEG; g++) begin : g_unpack
        assign words[g] = in_words[g*WORD_W +: WORD_W];
    end

    cnu_extrinsic u_front (
        .words (words),
        .mid   (mid_d)
    );

    cnu_stage u_stage (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .d        (mid_d),
        .q_valid  (out_valid),
        .q        (mid_q)
    );

    cnu_lookup u_back (
        .q    (mid_q),
        .msgs (out_msgs)
    );

    assign out_parity = mid_q.parity;

endmodule

// File: rtl/ldpc_cnu_chk.sv
module ldpc_cnu_chk
    import ldpc_cnu_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  in_valid,
    input logic [DEG*WORD_W-1:0] in_words,
    input logic                  out_valid,
    input logic [DEG*MSG_W-1:0]  out_msgs,
    input logic                  out_parity
);

    // Lowest exclusion sum whose quantised transfer value is zero
    localparam int ZERO_FROM = 12;

    logic             hard_par;
    logic [DEG-1:0]   oth_sgn;
    logic [SUM_W-1:0] oth_sum [DEG];

    // Exclusion computed edge by edge, not via a total
    always_comb begin
        hard_par = 1'b0;
        for (int e = 0; e < DEG; e++)
            hard_par = hard_par ^ in_words[e*WORD_W + WORD_W - 1];
        for (int i = 0; i < DEG; i++) begin
            oth_sgn[i] = 1'b0;
            oth_sum[i] = '0;
            for (int e = 0; e < DEG; e++) begin
                if (e != i) begin
                    oth_sgn[i] = oth_sgn[i] ^ in_words[e*WORD_W + MAG_W];
                    oth_sum[i] = oth_sum[i] + SUM_W'(in_words[e*WORD_W +: MAG_W]);
                end
            end
        end
    end

    a_r1_reset_clears_valid: assert property (@(posedge clk)
        rst |=> !out_valid);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_parity: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_parity == $past(hard_par));

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_msgs) && $stable(out_parity));

    for (genvar g = 0; g < DEG; g++) begin : g_edge
        a_r4_sign: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_msgs[g*MSG_W + MAG_W] == $past(oth_sgn[g]));

        a_r5_silent_neighbours: assert property (@(posedge clk) disable iff (rst)
            in_valid && oth_sum[g] == '0 |=> out_msgs[g*MSG_W +: MAG_W] == MAG_W'(MAG_MAX));

        a_r6_no_wrap: assert property (@(posedge clk) disable iff (rst)
            in_valid && oth_sum[g] >= SUM_W'(ZERO_FROM) |=> out_msgs[g*MSG_W +: MAG_W] == '0);
    end

endmodule

bind ldpc_cnu ldpc_cnu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_words   (in_words),
    .out_valid  (out_valid),
    .out_msgs   (out_msgs),
    .out_parity (out_parity)
);

// File: tb/ldpc_cnu_bench.sv
module ldpc_cnu_bench;
    import ldpc_cnu_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  in_valid;
    logic [DEG*WORD_W-1:0] in_words;
    logic                  out_valid;
    logic [DEG*MSG_W-1:0]  out_msgs;
    logic                  out_parity;

    always #10 clk = ~clk;

    ldpc_cnu u_ldpc_cnu (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_words   (in_words),
        .out_valid  (out_valid),
        .out_msgs   (out_msgs),
        .out_parity (out_parity)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state
    bit m_valid = 0;
    bit m_have  = 0;
    bit m_par   = 0;
    int m_sgn [DEG];
    int m_mag [DEG];
    int m_sum [DEG];

    function automatic int ref_mag(int s);
        real x, f;
        int  q;
        if (s == 0) return 15;
        x = s / 4.0;
        f = $ln((1.0 + $exp(-x)) / (1.0 - $exp(-x)));
        q = $rtoi(f * 4.0 + 0.5);
        return (q > 15) ? 15 : q;
    endfunction

    function automatic logic [DEG*WORD_W-1:0] mk(int h[DEG], int s[DEG], int m[DEG]);
        logic [DEG*WORD_W-1:0] w;
        for (int e = 0; e < DEG; e++)
            w[e*WORD_W +: WORD_W] = {h[e][0], s[e][0], m[e][3:0]};
        return w;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, then compare all outputs against the model
    task automatic step(bit v, logic [DEG*WORD_W-1:0] w);
        in_valid = v;
        in_words = w;
        @(negedge clk);
        if (v) begin
            m_have = 1;
            m_par  = 0;
            for (int e = 0; e < DEG; e++) m_par ^= w[e*WORD_W + 5];
            for (int i = 0; i < DEG; i++) begin
                int s = 0, g = 0;
                for (int e = 0; e < DEG; e++) begin
                    if (e != i) begin
                        s += int'(w[e*WORD_W +: 4]);
                        g ^= int'(w[e*WORD_W + 4]);
                    end
                end
                m_sum[i] = s;
                m_sgn[i] = g;
                m_mag[i] = ref_mag(s);
            end
        end
        m_valid = v;
        chk(out_valid == m_valid, "R2", out_valid, m_valid);
        if (m_have) begin
            chk(out_parity == m_par, v ? "R3" : "R9", out_parity, m_par);
            for (int i = 0; i < DEG; i++) begin
                int asg = int'(out_msgs[i*MSG_W + 4]);
                int amg = int'(out_msgs[i*MSG_W +: 4]);
                chk(asg == m_sgn[i], v ? "R4" : "R9", asg, m_sgn[i]);
                chk(amg == m_mag[i], !v ? "R9" : (m_sum[i] >= 15) ? "R6" : "R5", amg, m_mag[i]);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int h[DEG], s[DEG], m[DEG];
        logic [DEG*MSG_W-1:0]  saved;
        logic [DEG*WORD_W-1:0] w;
        rst = 1; in_valid = 0; in_words = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        rst = 0;

        // R5: all silent neighbours give the maximum
        foreach (h[e]) begin h[e] = 0; s[e] = 0; m[e] = 0; end
        step(1, mk(h, s, m));
        // R6: all full magnitudes, sum 75 saturates to zero
        foreach (h[e]) begin h[e] = 1; s[e] = e & 1; m[e] = 15; end
        step(1, mk(h, s, m));
        // R5: single small magnitude
        foreach (h[e]) begin h[e] = 0; s[e] = 0; m[e] = 0; end
        m[0] = 1; s[0] = 1; h[0] = 1;
        step(1, mk(h, s, m));
        // R3/R4: mixed hard and sign patterns
        h = '{1,0,1,1,0,0}; s = '{0,1,1,0,1,0}; m = '{1,2,3,0,0,0};
        step(1, mk(h, s, m));
        // R6: boundary around the table range (14, 15, 16)
        h = '{0,0,0,0,0,0}; s = '{0,0,0,0,0,0};
        m = '{0,3,3,3,3,2}; step(1, mk(h, s, m));
        m = '{0,3,3,3,3,3}; step(1, mk(h, s, m));
        m = '{0,4,3,3,3,3}; step(1, mk(h, s, m));
        m = '{7,4,2,1,1,1}; step(1, mk(h, s, m));
        // R9: idle cycles hold the outputs
        saved = out_msgs;
        step(0, '1); step(0, '0); step(0, mk(h, s, m));
        chk(out_msgs == saved, "R9", int'(out_msgs), int'(saved));

        // R7: hard bits and signs leave magnitudes alone
        h = '{0,1,0,0,1,1}; s = '{1,0,0,1,1,0}; m = '{2,5,1,0,3,4};
        step(1, mk(h, s, m));
        saved = out_msgs;
        w = mk(h, s, m);
        for (int e = 0; e < DEG; e++) w[e*WORD_W + 5] = ~w[e*WORD_W + 5];
        step(1, w);
        chk(out_msgs == saved, "R7", int'(out_msgs), int'(saved));
        for (int e = 0; e < DEG; e++) w[e*WORD_W + 4] = ~w[e*WORD_W + 4];
        step(1, w);
        for (int i = 0; i < DEG; i++)
            chk(out_msgs[i*MSG_W +: 4] == saved[i*MSG_W +: 4], "R7",
                int'(out_msgs[i*MSG_W +: 4]), int'(saved[i*MSG_W +: 4]));

        // R8: own magnitude does not reach its own output
        m[0] = 3; step(1, mk(h, s, m));
        saved = out_msgs;
        m[0] = 9; step(1, mk(h, s, m));
        chk(out_msgs[3:0] == saved[3:0], "R8", int'(out_msgs[3:0]), int'(saved[3:0]));

        // Random traffic with gaps
        for (int k = 0; k < 4000; k++) begin
            for (int e = 0; e < DEG; e++) begin
                h[e] = $urandom_range(1);
                s[e] = $urandom_range(1);
                m[e] = (k < 1000) ? $urandom_range(4) : $urandom_range(15);
            end
            step(($urandom_range(3) != 0), mk(h, s, m));
        end

        // R1: reset in the middle of traffic
        rst = 1;
        in_valid = 1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", out_valid, 0);
        rst = 0;
        in_valid = 0;
        @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule